// File: doc/BRIEF.md
# Region-Based Memory Access Security Filter

This block sits in front of a memory target and decides, in the same cycle, whether each request may pass. Software programs a set of address windows over a 32-bit register port. Each window has a base, a power-of-two size and four grant bits: read and write, for secure and for non-secure requesters. A granted request is forwarded to memory and its read data returns unchanged. A refused request never reaches memory, and its read data is forced to zero.

A refusal is recorded in a fault record: the address, the direction, the security state and the requester tag. A pending flag is raised alongside it. A two-bit action setting chooses whether a refusal produces a bus error on the request path, an interrupt, both, or neither. A later refusal while the flag is still pending only sets an overrun flag and leaves the record as it was. Window 0 is a fixed background window that covers every address. It refuses everything until software grants it permissions.

Top module: `region_guard`

## Requirements
- R1: The register at offset 0x000 is read-only and returns the window count minus one in bits 3:0 and the address width minus one in bits 13:8, with all other bits zero.
- R2: Window n has three registers at 0x100 + 0x10*n:
  - +0x0 holds the low 32 base bits.
  - +0x4 holds the upper base bits.
  - +0x8 holds the attributes: bit 0 enable, bits 6:1 size code, bits 31:28 grants.
  - All three read back what was written, except that the enable bit of window 0 always reads 1.
- R3: Window 0 is always enabled and matches every address. After reset all its grants are 0, so every request is refused until software grants it permissions.
- R4: A window with size code s spans 2^(s+1) bytes. The low s+1 base bits are ignored in the comparison. A code below 0x0E is treated as 0x0E.
- R5: The comparison uses the full request address, including the bits held in the upper base word.
- R6: Attribute bit 28 grants non-secure write, bit 29 non-secure read, bit 30 secure write and bit 31 secure read.
- R7: When several enabled windows match an address, the highest-numbered one alone decides. A disabled window has no effect.
- R8: A refused request leaves `mem_valid` low and returns zero on `acc_rdata`. A granted request raises `mem_valid` and passes `mem_rdata` through. Both happen in the same cycle as the request.
- R9: The action register at 0x004 (bits 1:0) reads back its value. `acc_err` is high in the cycle of a refused request exactly when action bit 0 is set.
- R10: `irq` is high whenever the pending flag is set and action bit 1 is set.
- R11: A refusal while nothing is pending sets status bit 0 (at 0x010) on the next edge and captures four fields:
  - the low address word at 0x020;
  - the upper address bits at 0x024;
  - the control word at 0x028, with bit 0 = write and bit 1 = secure;
  - the requester tag at 0x02C.
- R12: A refusal while pending is set sets status bit 1 (overrun) and leaves the record unchanged. Writing 1 to bit 0 at 0x014 clears both status bits, and the next refusal is captured afresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_addr | input | 12 | Register byte offset |
| cfg_wdata | input | 32 | Register write data |
| cfg_rdata | output | 32 | Register read data (combinational on `cfg_addr`) |
| acc_valid | input | 1 | Request present |
| acc_write | input | 1 | Request is a write |
| acc_secure | input | 1 | Requester is secure |
| acc_id | input | ID_W | Requester tag |
| acc_addr | input | ADDR_W | Request address |
| acc_rdata | output | DATA_W | Read data returned to the requester |
| acc_err | output | 1 | Error response for a refused request |
| mem_valid | output | 1 | Request forwarded to memory |
| mem_rdata | input | DATA_W | Read data from memory |
| irq | output | 1 | Violation interrupt |

## Verification
The bench builds the block with its defaults: nine windows, a 40-bit address, 32-bit data and a 4-bit tag. With a 40-bit address, the upper base word and the upper fault-address word carry real bits, so a window placed above 4 GB and a fault at a high address can both be observed. Nine windows leave room for a background, an outer window, a nested inner window and a disabled window that overlap the same addresses, so the priority order and the enable bit can be checked against each other.

// File: rtl/region_guard.sv
module region_guard #(
  parameter int NUM_REGIONS = 9,
  parameter int ADDR_W      = 40,
  parameter int DATA_W      = 32,
  parameter int ID_W        = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [11:0]       cfg_addr,
  input  logic [31:0]       cfg_wdata,
  output logic [31:0]       cfg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_secure,
  input  logic [ID_W-1:0]   acc_id,
  input  logic [ADDR_W-1:0] acc_addr,
  output logic [DATA_W-1:0] acc_rdata,
  output logic              acc_err,
  output logic              mem_valid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq
);
  localparam int HI_W = ADDR_W - 32;
  localparam logic [5:0] MIN_CODE = 6'd14;
  localparam logic [31:0] BUILD_WORD =
    {18'd0, 6'(ADDR_W - 1), 4'd0, 4'(NUM_REGIONS - 1)};

  logic [ADDR_W-1:0] base_q [NUM_REGIONS];
  logic [5:0]        size_q [NUM_REGIONS];
  logic [3:0]        perm_q [NUM_REGIONS];
  logic [NUM_REGIONS-1:0] en_q;
  logic [NUM_REGIONS-1:0] hit;

  logic [1:0]        act_q;
  logic              pend_q, ovr_q;
  logic [ADDR_W-1:0] flt_addr_q;
  logic              flt_wr_q, flt_sec_q;
  logic [ID_W-1:0]   flt_id_q;

  wire       rgn_sel = cfg_addr[11:8] == 4'h1;
  wire [3:0] rgn_idx = cfg_addr[7:4];
  wire [1:0] rgn_sub = cfg_addr[3:2];
  wire       clr_hit = cfg_wr && cfg_addr == 12'h014 && cfg_wdata[0];
  wire       act_wr  = cfg_wr && cfg_addr == 12'h004;

  for (genvar r = 0; r < NUM_REGIONS; r++) begin : g_rgn
    logic [5:0]        code;
    logic [ADDR_W-1:0] keep;
    wire               wr_me = cfg_wr && rgn_sel && rgn_idx == 4'(r);

    assign code = (r == 0) ? 6'd63 :
                  (size_q[r] < MIN_CODE) ? MIN_CODE : size_q[r];

    always_comb
      for (int i = 0; i < ADDR_W; i++)
        keep[i] = i > int'(code);

    assign hit[r] = ((r == 0) || en_q[r]) &&
                    (((acc_addr ^ base_q[r]) & keep) == '0);

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) begin
        base_q[r] <= '0;
        size_q[r] <= '0;
        perm_q[r] <= '0;
        en_q[r]   <= 1'b0;
      end else if (wr_me) begin
        case (rgn_sub)
          2'd0: base_q[r][31:0]       <= cfg_wdata;
          2'd1: base_q[r][ADDR_W-1:32] <= cfg_wdata[HI_W-1:0];
          2'd2: begin
            en_q[r]   <= cfg_wdata[0];
            size_q[r] <= cfg_wdata[6:1];
            perm_q[r] <= cfg_wdata[31:28];
          end
          default: ;
        endcase
      end
  end

  logic [3:0] win_perm;
  always_comb begin
    win_perm = perm_q[0];
    for (int r = 1; r < NUM_REGIONS; r++)
      if (hit[r]) win_perm = perm_q[r];
  end

  wire allow = win_perm[{acc_secure, ~acc_write}];
  wire viol  = acc_valid && !allow;

  assign mem_valid = acc_valid && allow;
  assign acc_rdata = mem_valid ? mem_rdata : '0;
  assign acc_err   = viol && act_q[0];
  assign irq       = pend_q && act_q[1];

  wire pend_live = pend_q && !clr_hit;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      act_q      <= 2'd0;
      pend_q     <= 1'b0;
      ovr_q      <= 1'b0;
      flt_addr_q <= '0;
      flt_wr_q   <= 1'b0;
      flt_sec_q  <= 1'b0;
      flt_id_q   <= '0;
    end else begin
      if (act_wr) act_q <= cfg_wdata[1:0];
      if (clr_hit) begin
        pend_q <= 1'b0;
        ovr_q  <= 1'b0;
      end
      if (viol) begin
        if (!pend_live) begin
          pend_q     <= 1'b1;
          flt_addr_q <= acc_addr;
          flt_wr_q   <= acc_write;
          flt_sec_q  <= acc_secure;
          flt_id_q   <= acc_id;
        end else begin
          ovr_q <= 1'b1;
        end
      end
    end

  always_comb begin
    cfg_rdata = '0;
    case (cfg_addr)
      12'h000: cfg_rdata = BUILD_WORD;
      12'h004: cfg_rdata = {30'd0, act_q};
      12'h010: cfg_rdata = {30'd0, ovr_q, pend_q};
      12'h020: cfg_rdata = flt_addr_q[31:0];
      12'h024: cfg_rdata = 32'(flt_addr_q[ADDR_W-1:32]);
      12'h028: cfg_rdata = {30'd0, flt_sec_q, flt_wr_q};
      12'h02C: cfg_rdata = 32'(flt_id_q);
      default:
        if (rgn_sel)
          for (int r = 0; r < NUM_REGIONS; r++)
            if (rgn_idx == 4'(r))
              case (rgn_sub)
                2'd0: cfg_rdata = base_q[r][31:0];
                2'd1: cfg_rdata = 32'(base_q[r][ADDR_W-1:32]);
                2'd2: cfg_rdata = {perm_q[r], 21'd0, size_q[r],
                                   (r == 0) ? 1'b1 : en_q[r]};
                default: cfg_rdata = '0;
              endcase
    endcase
  end
endmodule

// File: rtl/region_guard_chk.sv
module region_guard_chk #(
  parameter int ADDR_W = 40,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              acc_valid,
  input logic              mem_valid,
  input logic [DATA_W-1:0] acc_rdata,
  input logic              acc_err,
  input logic              irq,
  input logic [1:0]        act_q,
  input logic              pend_q,
  input logic              ovr_q,
  input logic              clr_hit,
  input logic [ADDR_W-1:0] flt_addr_q
);
  assert_refused_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mem_valid) |-> acc_rdata == '0);

  assert_err_only_refused_R9: assert property (@(posedge clk) disable iff (!rst_n)
    acc_err |-> (act_q[0] && acc_valid && !mem_valid));

  assert_irq_needs_pending_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> pend_q);

  assert_first_fault_sets_pending_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && !mem_valid && !pend_q) |=> pend_q);

  assert_record_held_R12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(pend_q) && !$past(clr_hit)) |-> flt_addr_q == $past(flt_addr_q));

  assert_overrun_set_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend_q && acc_valid && !mem_valid && !clr_hit) |=> ovr_q);
endmodule

bind region_guard region_guard_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .acc_valid(acc_valid), .mem_valid(mem_valid),
  .acc_rdata(acc_rdata), .acc_err(acc_err), .irq(irq), .act_q(act_q),
  .pend_q(pend_q), .ovr_q(ovr_q), .clr_hit(clr_hit), .flt_addr_q(flt_addr_q)
);

// File: tb/sim_region_guard.sv
module sim_region_guard;
  localparam int CLK_PERIOD = 10;
  localparam logic [31:0] MEM_WORD = 32'hA5A5_0001;

  logic        clk, rst_n;
  logic        cfg_wr;
  logic [11:0] cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic        acc_valid, acc_write, acc_secure;
  logic [3:0]  acc_id;
  logic [39:0] acc_addr;
  logic [31:0] acc_rdata, mem_rdata;
  logic        acc_err, mem_valid, irq;

  int n_tests = 0, n_fail = 0;
  logic        s_fwd, s_err;
  logic [31:0] s_data;

  region_guard u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .acc_valid(acc_valid),
    .acc_write(acc_write), .acc_secure(acc_secure), .acc_id(acc_id),
    .acc_addr(acc_addr), .acc_rdata(acc_rdata), .acc_err(acc_err),
    .mem_valid(mem_valid), .mem_rdata(mem_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr = 1'b0;
  endtask

  task automatic rd_chk(string tag, logic [11:0] a, logic [31:0] exp);
    @(negedge clk);
    cfg_addr = a; #1;
    chk(tag, 64'(cfg_rdata), 64'(exp));
  endtask

  task automatic probe(logic [39:0] a, logic w, logic s, logic [3:0] id);
    @(negedge clk);
    acc_valid = 1'b1; acc_addr = a; acc_write = w; acc_secure = s; acc_id = id;
    #1;
    s_fwd = mem_valid; s_err = acc_err; s_data = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic expect_access(string tag, logic [39:0] a, logic w, logic s, logic ok);
    probe(a, w, s, 4'd0);
    chk(tag, 64'(s_fwd), 64'(ok));
    chk(tag, 64'(s_data), ok ? 64'(MEM_WORD) : 64'd0);
  endtask

  task automatic t_reset;
    rd_chk("R1 build word", 12'h000, 32'h0000_2708);
    rd_chk("R12 status after reset", 12'h010, 32'h0);
    rd_chk("R9 action after reset", 12'h004, 32'h0);
    rd_chk("R2 window0 attr after reset", 12'h108, 32'h1);
    chk("R10 irq after reset", 64'(irq), 64'd0);
    chk("R8 idle not forwarded", 64'(mem_valid), 64'd0);
  endtask

  task automatic t_default_deny;
    probe(40'h00_1234_5678, 1'b0, 1'b1, 4'd5);
    chk("R3 default refuse", 64'(s_fwd), 64'd0);
    chk("R8 zero read data", 64'(s_data), 64'd0);
    rd_chk("R11 pending", 12'h010, 32'h1);
    rd_chk("R11 addr low", 12'h020, 32'h1234_5678);
    rd_chk("R11 addr high", 12'h024, 32'h0);
    rd_chk("R11 control", 12'h028, 32'h2);
    rd_chk("R11 id", 12'h02C, 32'h5);
    probe(40'h00_0000_2000, 1'b1, 1'b0, 4'd1);
    chk("R8 refused write not forwarded", 64'(s_fwd), 64'd0);
    rd_chk("R12 overrun", 12'h010, 32'h3);
    rd_chk("R12 record kept", 12'h020, 32'h1234_5678);
    wr(12'h014, 32'h1);
    rd_chk("R12 cleared", 12'h010, 32'h0);
  endtask

  task automatic t_perm_bits;
    for (int k = 0; k < 4; k++) begin
      wr(12'h108, 32'h1 << (28 + k));
      for (int j = 0; j < 4; j++)
        expect_access($sformatf("R6 grant bit %0d combo %0d", 28 + k, j),
                      40'h00_0000_8000, ~j[0], j[1], j == k);
    end
    wr(12'h108, 32'h0);
    wr(12'h014, 32'h1);
  endtask

  task automatic t_size_align;
    wr(12'h130, 32'h4000_0123);
    wr(12'h134, 32'h0);
    wr(12'h138, 32'hC000_001D);
    expect_access("R4 window start", 40'h00_4000_0000, 1'b0, 1'b1, 1'b1);
    expect_access("R4 window last word", 40'h00_4000_7FFC, 1'b0, 1'b1, 1'b1);
    expect_access("R4 past window end", 40'h00_4000_8000, 1'b0, 1'b1, 1'b0);
    expect_access("R4 below window", 40'h00_3FFF_FFFC, 1'b0, 1'b1, 1'b0);
    expect_access("R6 non-secure refused", 40'h00_4000_0000, 1'b0, 1'b0, 1'b0);
    wr(12'h138, 32'hC000_0003);
    expect_access("R4 small code clamped in", 40'h00_4000_7FFC, 1'b0, 1'b1, 1'b1);
    expect_access("R4 small code clamped out", 40'h00_4000_8000, 1'b0, 1'b1, 1'b0);
    rd_chk("R2 attr readback", 12'h138, 32'hC000_0003);
    rd_chk("R2 base readback", 12'h130, 32'h4000_0123);
    wr(12'h014, 32'h1);
  endtask

  task automatic t_high_word;
    wr(12'h140, 32'h0);
    wr(12'h144, 32'h12);
    wr(12'h148, 32'hF000_003F);
    rd_chk("R2 high base readback", 12'h144, 32'h12);
    expect_access("R5 upper window hit", 40'h12_8000_0000, 1'b1, 1'b1, 1'b1);
    expect_access("R5 next 4G miss", 40'h13_0000_0000, 1'b1, 1'b1, 1'b0);
    expect_access("R5 low alias miss", 40'h00_8000_0000, 1'b1, 1'b1, 1'b0);
    rd_chk("R11 high fault addr", 12'h024, 32'h13);
    wr(12'h014, 32'h1);
  endtask

  task automatic t_priority;
    wr(12'h130, 32'h4000_0000);
    wr(12'h138, 32'hC000_0027);
    wr(12'h150, 32'h4001_0000);
    wr(12'h158, 32'h3000_001F);
    expect_access("R7 inner grants ns", 40'h00_4001_0010, 1'b0, 1'b0, 1'b1);
    expect_access("R7 inner refuses s", 40'h00_4001_0010, 1'b0, 1'b1, 1'b0);
    expect_access("R7 outer grants s", 40'h00_4002_0000, 1'b0, 1'b1, 1'b1);
    expect_access("R7 outer refuses ns", 40'h00_4002_0000, 1'b0, 1'b0, 1'b0);
    wr(12'h160, 32'h4001_0000);
    wr(12'h168, 32'hF000_001E);
    expect_access("R7 disabled window ignored", 40'h00_4001_0010, 1'b0, 1'b1, 1'b0);
    wr(12'h168, 32'hF000_001F);
    expect_access("R7 higher window wins", 40'h00_4001_0010, 1'b0, 1'b1, 1'b1);
    wr(12'h014, 32'h1);
  endtask

  task automatic t_action;
    for (int a = 0; a < 4; a++) begin
      wr(12'h004, 32'(a));
      rd_chk("R9 action readback", 12'h004, 32'(a));
      probe(40'h00_0000_0100, 1'b0, 1'b1, 4'd2);
      chk($sformatf("R9 err action %0d", a), 64'(s_err), 64'(a & 1));
      chk($sformatf("R10 irq action %0d", a), 64'(irq), 64'((a >> 1) & 1));
      wr(12'h014, 32'h1);
      chk("R10 irq after clear", 64'(irq), 64'd0);
    end
    expect_access("R9 grant no err", 40'h00_4002_0000, 1'b0, 1'b1, 1'b1);
    chk("R9 no err on grant", 64'(s_err), 64'd0);
    wr(12'h004, 32'h0);
  endtask

  task automatic t_overrun;
    probe(40'h00_0000_2000, 1'b1, 1'b0, 4'd9);
    rd_chk("R11 write ns control", 12'h028, 32'h1);
    probe(40'h00_0000_3000, 1'b0, 1'b1, 4'd3);
    rd_chk("R12 overrun set", 12'h010, 32'h3);
    rd_chk("R12 addr kept", 12'h020, 32'h2000);
    rd_chk("R12 id kept", 12'h02C, 32'h9);
    wr(12'h014, 32'h1);
    rd_chk("R12 both cleared", 12'h010, 32'h0);
    probe(40'h00_0000_4000, 1'b0, 1'b0, 4'd7);
    rd_chk("R12 fresh capture addr", 12'h020, 32'h4000);
    rd_chk("R12 fresh capture id", 12'h02C, 32'h7);
    rd_chk("R12 fresh pending only", 12'h010, 32'h1);
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    acc_valid = 1'b0; acc_write = 1'b0; acc_secure = 1'b0; acc_id = '0;
    acc_addr = '0; mem_rdata = MEM_WORD;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset;
    t_default_deny;
    t_perm_bits;
    t_size_align;
    t_high_word;
    t_priority;
    t_action;
    t_overrun;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule